// File: doc/BRIEF.md
# MMC Command Sequencer with Response Capture

This block runs a single command exchange with an MMC or SD card from the host side. Software loads a 6-bit command index and a 32-bit argument through a small register write port. The argument arrives as two independent 16-bit halves. Software then writes a command/data control word. The control word either issues the command at once or leaves it pending until the bus clock is started. A start-clock write will not issue a pending command while the control word's stop-transaction bit is set.

An issued command is presented on a card-side request/acknowledge port. The card answers with a byte count and up to 16 response bytes. The sequencer compares that count with the minimum the selected response class needs, and a response that is too short is reported as a response timeout. A response of adequate length is packed two bytes per halfword into a 9-entry response FIFO, which software drains through the read port.

After a good response the block either returns to idle or pulses a start signal to a separate data engine, giving the transfer direction with it. Line encoding and CRC generation are not part of this block.

Top module: `mmc_cmd_sequencer`

## Requirements
- R1: Register select 0 holds the command index (6 bits, upper write bits dropped). Its readback is the index with bit 6 set and bits 15:7 zero.
- R2: Select 1 writes argument bits 31:16 and select 2 writes bits 15:0. Each write leaves the other half unchanged, and each half reads back on its own select.
- R3: A write to the control word (select 3) stores the written value ANDed with 0x3DFF, and the stored value reads back on select 3. The write also clears the response-timeout (bit 1) and response-done (bit 13) bits of the status word (select 5).
- R4: A control write with bit 10 (stop-transaction) clear, made while the clock is enabled, raises card_req at the next edge, with card_cmd and card_arg showing the loaded index and argument. When bit 10 is set, no request is made, including on a later start-clock write.
- R5: The clock-control write (select 4) enables the clock when bit 1 is set and disables it when bit 0 is set, and status bit 8 shows the result. A control write made while the clock is off stays pending and is issued by the next start-clock write.
- R6: card_req stays high until the cycle in which card_ack is sampled high. In the following cycle evt_end_cmd pulses for exactly one cycle, for every command, good or short.
- R7: The response class in control bits 1:0 needs at least this many bytes: class 0 needs 0, class 2 needs 16, and classes 1 and 3 need 4. A shorter card_rsp_len sets status bit 1, leaves bit 13 clear and starts no data phase.
- R8: On a good response, FIFO entry j holds byte 2j in bits 7:0 and byte 2j+1 in bits 15:8, where byte i is card_rsp_data[8i+7:8i]. Bytes at or beyond card_rsp_len read as zero, and status bit 13 is set.
- R9: Each read on select 6 returns the next FIFO entry, starting from entry 0 after a good response. The tenth and later reads return zero.
- R10: After a good response with control bit 2 set, data_start pulses once together with the response capture, and data_write equals control bit 3. With bit 2 clear, data_start stays low.
- R11: While a request is outstanding, writes to the index, argument and control registers are ignored, and card_cmd, card_arg and the control readback keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe; advances the response FIFO on select 6 |
| rd_sel | input | 3 | Register select for the read |
| rd_data | output | 16 | Read data, combinational from rd_sel |
| card_req | output | 1 | Command request to the card port |
| card_cmd | output | 6 | Command index presented with the request |
| card_arg | output | 32 | Argument presented with the request |
| card_ack | input | 1 | Card has answered; length and bytes are valid |
| card_rsp_len | input | 5 | Number of valid response bytes (0 to 16) |
| card_rsp_data | input | 128 | Response bytes, byte i in bits 8i+7:8i |
| evt_end_cmd | output | 1 | One-cycle end-of-command event |
| data_start | output | 1 | One-cycle start pulse to the data engine |
| data_write | output | 1 | Direction for the data phase, 1 meaning write |
| busy | output | 1 | A command request is outstanding |

## Verification
On every cycle the assertions check several properties. The request is held, with a stable index and argument, until it is acknowledged. The end-of-command event never lasts beyond one cycle. The timeout and response-done status bits are never set together. A data start occurs only after a good response. A request never rises while the clock is off, and the FIFO read pointer stays inside its range. The bench scenarios cover the rest: every response class is swept against every byte count from 0 to 16, the packed halfwords and zero padding are compared with computed values, and the deferral, stop-transaction and ignored-write cases are exercised.

// File: rtl/mmc_cmd_pkg.sv
package mmc_cmd_pkg;

   typedef enum logic [2:0] {
      SEL_CMD  = 3'd0,
      SEL_ARGH = 3'd1,
      SEL_ARGL = 3'd2,
      SEL_CTRL = 3'd3,
      SEL_CLK  = 3'd4,
      SEL_STAT = 3'd5,
      SEL_RESP = 3'd6
   } reg_sel_e;

   localparam int          HALF_W        = 16;
   localparam logic [15:0] CTRL_KEEP     = 16'h3DFF;
   localparam int          CTRL_DEN_BIT  = 2;
   localparam int          CTRL_DIR_BIT  = 3;
   localparam int          CTRL_STOP_BIT = 10;
   localparam int          CLK_STOP_BIT  = 0;
   localparam int          CLK_START_BIT = 1;
   localparam int          ST_TOUT_BIT   = 1;
   localparam int          ST_CLK_BIT    = 8;
   localparam int          ST_DONE_BIT   = 13;
   localparam int          LONG_RSP      = 16;
   localparam int          SHORT_RSP     = 4;

   // minimum byte count for a response class
   function automatic int unsigned rsp_need(input logic [1:0] cls);
      case (cls)
         2'd0:    rsp_need = 0;
         2'd2:    rsp_need = LONG_RSP;
         default: rsp_need = SHORT_RSP;
      endcase
   endfunction

endpackage

// File: rtl/mmc_cmd_regs.sv
module mmc_cmd_regs
   import mmc_cmd_pkg::*;
#(
   parameter int IDX_W = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [2:0]          wr_sel,
   input  logic [HALF_W-1:0]   wr_data,
   input  logic                busy,
   output logic [IDX_W-1:0]    cmd_idx,
   output logic [2*HALF_W-1:0] arg,
   output logic [HALF_W-1:0]   ctrl,
   output logic                clk_en,
   output logic                issue,
   output logic                stat_clr
);

   logic pending;
   logic fld_wr, ctrl_wr, clk_wr, start_ok;

   assign fld_wr   = wr_en && !busy;
   assign ctrl_wr  = fld_wr && (wr_sel == SEL_CTRL);
   assign clk_wr   = wr_en && (wr_sel == SEL_CLK);
   assign start_ok = clk_wr && wr_data[CLK_START_BIT] && !wr_data[CLK_STOP_BIT];

   assign issue = !busy &&
                  ((ctrl_wr && !wr_data[CTRL_STOP_BIT] && clk_en) ||
                   (start_ok && pending && !ctrl[CTRL_STOP_BIT]));
   assign stat_clr = ctrl_wr || issue;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_idx <= '0;
         arg     <= '0;
         ctrl    <= '0;
         clk_en  <= 1'b0;
         pending <= 1'b0;
      end else begin
         if (fld_wr && wr_sel == SEL_CMD)  cmd_idx <= wr_data[IDX_W-1:0];
         if (fld_wr && wr_sel == SEL_ARGH) arg[2*HALF_W-1:HALF_W] <= wr_data;
         if (fld_wr && wr_sel == SEL_ARGL) arg[HALF_W-1:0] <= wr_data;
         if (ctrl_wr)                      ctrl <= wr_data & CTRL_KEEP;
         if (clk_wr && wr_data[CLK_START_BIT]) clk_en <= 1'b1;
         if (clk_wr && wr_data[CLK_STOP_BIT])  clk_en <= 1'b0;
         if (issue)        pending <= 1'b0;
         else if (ctrl_wr) pending <= 1'b1;
      end
   end

   // R5: an issued command is no longer pending afterwards
   p_pending_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> !pending);

endmodule

// File: rtl/mmc_rsp_pack.sv
module mmc_rsp_pack
   import mmc_cmd_pkg::*;
#(
   parameter int RSP_BYTES  = 16,
   parameter int FIFO_DEPTH = 9,
   parameter int LEN_W      = 5
) (
   input  logic [1:0]                         rsp_cls,
   input  logic [LEN_W-1:0]                   rsp_len,
   input  logic [RSP_BYTES*8-1:0]             rsp_data,
   output logic                               rsp_ok,
   output logic [FIFO_DEPTH-1:0][HALF_W-1:0]  halves
);

   assign rsp_ok = 32'(rsp_len) >= rsp_need(rsp_cls);

   for (genvar j = 0; j < FIFO_DEPTH; j++) begin : g_half
      localparam int LO = 2*j;
      localparam int HI = 2*j + 1;
      if (HI < RSP_BYTES) begin : g_full
         assign halves[j][7:0]  = (32'(rsp_len) > LO) ? rsp_data[LO*8 +: 8] : 8'h00;
         assign halves[j][15:8] = (32'(rsp_len) > HI) ? rsp_data[HI*8 +: 8] : 8'h00;
      end else if (LO < RSP_BYTES) begin : g_low
         assign halves[j][7:0]  = (32'(rsp_len) > LO) ? rsp_data[LO*8 +: 8] : 8'h00;
         assign halves[j][15:8] = 8'h00;
      end else begin : g_none
         assign halves[j] = '0;
      end
   end

endmodule

// File: rtl/mmc_rsp_fifo.sv
module mmc_rsp_fifo
   import mmc_cmd_pkg::*;
#(
   parameter int DEPTH = 9
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load,
   input  logic [DEPTH-1:0][HALF_W-1:0]  load_data,
   input  logic                          pop,
   output logic [HALF_W-1:0]             head
);

   localparam int PW = $clog2(DEPTH + 1);
   localparam logic [PW-1:0] PTR_END = PW'(DEPTH);

   logic [DEPTH-1:0][HALF_W-1:0] mem;
   logic [PW-1:0]                ptr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem <= '0;
         ptr <= PTR_END;
      end else if (load) begin
         mem <= load_data;
         ptr <= '0;
      end else if (pop && ptr < PTR_END) begin
         ptr <= ptr + 1'b1;
      end
   end

   always_comb begin
      head = '0;
      for (int k = 0; k < DEPTH; k++)
         if (ptr == PW'(k)) head = mem[k];
   end

   // R9: the read pointer never passes the end
   p_ptr_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= PTR_END);
   // R9: reads past the end leave the pointer parked
   p_ptr_parked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !load && ptr == PTR_END) |=> ptr == PTR_END);

endmodule

// File: rtl/mmc_cmd_sequencer.sv
module mmc_cmd_sequencer
   import mmc_cmd_pkg::*;
#(
   parameter  int IDX_W      = 6,
   parameter  int RSP_BYTES  = 16,
   parameter  int FIFO_DEPTH = 9,
   localparam int LEN_W      = $clog2(RSP_BYTES + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [2:0]             wr_sel,
   input  logic [15:0]            wr_data,
   input  logic                   rd_en,
   input  logic [2:0]             rd_sel,
   output logic [15:0]            rd_data,
   output logic                   card_req,
   output logic [IDX_W-1:0]       card_cmd,
   output logic [31:0]            card_arg,
   input  logic                   card_ack,
   input  logic [LEN_W-1:0]       card_rsp_len,
   input  logic [RSP_BYTES*8-1:0] card_rsp_data,
   output logic                   evt_end_cmd,
   output logic                   data_start,
   output logic                   data_write,
   output logic                   busy
);

   if (RSP_BYTES < LONG_RSP)          begin : g_chk_bytes $error("RSP_BYTES below long response size"); end
   if (FIFO_DEPTH * 2 < RSP_BYTES)    begin : g_chk_depth $error("FIFO_DEPTH too small for RSP_BYTES"); end
   if (IDX_W < 1 || IDX_W > 15)       begin : g_chk_idx   $error("IDX_W out of range"); end

   logic [IDX_W-1:0]              cmd_idx;
   logic [31:0]                   arg;
   logic [15:0]                   ctrl;
   logic                          clk_en, issue, stat_clr;
   logic                          rsp_ok, take;
   logic [FIFO_DEPTH-1:0][15:0]   halves;
   logic [15:0]                   fifo_head;
   logic                          st_tout, st_done;

   mmc_cmd_regs #(.IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .busy(card_req), .cmd_idx(cmd_idx), .arg(arg), .ctrl(ctrl), .clk_en(clk_en),
      .issue(issue), .stat_clr(stat_clr)
   );

   mmc_rsp_pack #(.RSP_BYTES(RSP_BYTES), .FIFO_DEPTH(FIFO_DEPTH), .LEN_W(LEN_W)) u_pack (
      .rsp_cls(ctrl[1:0]), .rsp_len(card_rsp_len), .rsp_data(card_rsp_data),
      .rsp_ok(rsp_ok), .halves(halves)
   );

   assign take = card_req && card_ack;

   mmc_rsp_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .load(take && rsp_ok), .load_data(halves),
      .pop(rd_en && rd_sel == SEL_RESP), .head(fifo_head)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         card_req    <= 1'b0;
         st_tout     <= 1'b0;
         st_done     <= 1'b0;
         evt_end_cmd <= 1'b0;
         data_start  <= 1'b0;
         data_write  <= 1'b0;
      end else begin
         if (issue)     card_req <= 1'b1;
         else if (take) card_req <= 1'b0;
         if (stat_clr) begin
            st_tout <= 1'b0;
            st_done <= 1'b0;
         end else if (take) begin
            st_tout <= !rsp_ok;
            st_done <= rsp_ok;
         end
         evt_end_cmd <= take;
         data_start  <= take && rsp_ok && ctrl[CTRL_DEN_BIT];
         if (take && rsp_ok && ctrl[CTRL_DEN_BIT]) data_write <= ctrl[CTRL_DIR_BIT];
      end
   end

   assign card_cmd = cmd_idx;
   assign card_arg = arg;
   assign busy     = card_req;

   always_comb begin
      rd_data = '0;
      case (rd_sel)
         SEL_CMD:  rd_data = 16'(cmd_idx) | (16'h1 << IDX_W);
         SEL_ARGH: rd_data = arg[31:16];
         SEL_ARGL: rd_data = arg[15:0];
         SEL_CTRL: rd_data = ctrl;
         SEL_STAT: begin
            rd_data[ST_TOUT_BIT] = st_tout;
            rd_data[ST_CLK_BIT]  = clk_en;
            rd_data[ST_DONE_BIT] = st_done;
         end
         SEL_RESP: rd_data = fifo_head;
         default:  rd_data = '0;
      endcase
   end

   // R6: request held until acknowledged
   p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (card_req && !card_ack) |=> card_req);
   // R6: end-of-command event is a single-cycle pulse
   p_end_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      evt_end_cmd |=> !evt_end_cmd);
   // R11: command fields frozen while the request is outstanding
   p_fields_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (card_req && !card_ack) |=> ($stable(card_cmd) && $stable(card_arg)));
   // R7: timeout and response-done are exclusive
   p_status_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(st_tout && st_done));
   // R10: data phase only after a good response
   p_start_good_r10: assert property (@(posedge clk) disable iff (!rst_n)
      data_start |-> (st_done && evt_end_cmd));
   // R5: no request rises while the clock is off
   p_clk_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(card_req) |-> clk_en);

endmodule

// File: tb/sim_mmc_cmd_sequencer.sv
module sim_mmc_cmd_sequencer;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [2:0]   wr_sel = '0;
   logic [15:0]  wr_data = '0;
   logic         rd_en = 1'b0;
   logic [2:0]   rd_sel = '0;
   logic [15:0]  rd_data;
   logic         card_req;
   logic [5:0]   card_cmd;
   logic [31:0]  card_arg;
   logic         card_ack = 1'b0;
   logic [4:0]   card_rsp_len = '0;
   logic [127:0] card_rsp_data = '0;
   logic         evt_end_cmd, data_start, data_write, busy;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #2 clk = ~clk;

   mmc_cmd_sequencer u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .card_req(card_req),
      .card_cmd(card_cmd), .card_arg(card_arg), .card_ack(card_ack),
      .card_rsp_len(card_rsp_len), .card_rsp_data(card_rsp_data),
      .evt_end_cmd(evt_end_cmd), .data_start(data_start), .data_write(data_write),
      .busy(busy)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] s, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] s, output logic [15:0] d);
      @(negedge clk);
      rd_en = 1'b1; rd_sel = s;
      #1 d = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   // drive one acknowledge at the current negedge; returns at the next negedge
   task automatic ack(input logic [4:0] len, input logic [127:0] bytes);
      card_ack = 1'b1; card_rsp_len = len; card_rsp_data = bytes;
      @(negedge clk);
      card_ack = 1'b0;
   endtask

   function automatic logic [7:0] pat(input int n, input int i);
      return 8'((n * 16 + i * 7 + 3) & 255);
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] v;
      logic [127:0] bv;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk("R6 reset req", 32'(card_req), 0);
      rd(3'd5, v); chk("R5 reset status", 32'(v), 0);
      rd(3'd6, v); chk("R9 reset fifo", 32'(v), 0);

      // R1 index width and readback
      wr(3'd0, 16'hFFFF); rd(3'd0, v); chk("R1 idx readback", 32'(v), 32'h007F);
      wr(3'd0, 16'h0005); rd(3'd0, v); chk("R1 idx readback", 32'(v), 32'h0045);

      // R2 halves
      wr(3'd1, 16'hABCD); wr(3'd2, 16'h1234);
      wr(3'd1, 16'h5678);
      rd(3'd1, v); chk("R2 high half", 32'(v), 32'h5678);
      rd(3'd2, v); chk("R2 low kept", 32'(v), 32'h1234);
      chk("R2 arg port", card_arg, 32'h5678_1234);

      // R3 mask, R5 clock off defers
      wr(3'd3, 16'hFFFF); rd(3'd3, v); chk("R3 ctrl mask", 32'(v), 32'h3DFF);
      wr(3'd3, 16'h0001);
      repeat (3) @(negedge clk);
      chk("R5 deferred no req", 32'(card_req), 0);
      wr(3'd4, 16'h0002);
      chk("R5 start issues", 32'(card_req), 1);
      rd(3'd5, v); chk("R5 clk status", 32'(v[8]), 1);
      chk("R6 req held", 32'(card_req), 1);
      ack(5'd3, '0);
      chk("R6 end pulse", 32'(evt_end_cmd), 1);
      chk("R6 req dropped", 32'(card_req), 0);
      @(negedge clk);
      chk("R6 end pulse single", 32'(evt_end_cmd), 0);
      rd(3'd5, v); chk("R7 short timeout", 32'(v[1]), 1);
      chk("R7 short no done", 32'(v[13]), 0);

      // R3 clears status, R4 stop bit blocks
      wr(3'd3, 16'h0401);
      rd(3'd5, v); chk("R3 status cleared", 32'(v & 16'h2002), 0);
      chk("R4 stop no req", 32'(card_req), 0);
      wr(3'd4, 16'h0002);
      chk("R4 stop no req on start", 32'(card_req), 0);

      // R11 writes ignored while outstanding
      wr(3'd3, 16'h0001);
      chk("R4 immediate issue", 32'(card_req), 1);
      wr(3'd0, 16'h003F); wr(3'd3, 16'h0002); wr(3'd1, 16'h0000);
      chk("R11 cmd frozen", 32'(card_cmd), 32'h05);
      chk("R11 arg frozen", card_arg, 32'h5678_1234);
      rd(3'd3, v); chk("R11 ctrl frozen", 32'(v), 32'h0001);
      ack(5'd4, '0);
      @(negedge clk);

      // R5 stop clock then restart releases pending
      wr(3'd4, 16'h0001);
      rd(3'd5, v); chk("R5 clk off status", 32'(v[8]), 0);
      wr(3'd3, 16'h0000);
      chk("R5 off no req", 32'(card_req), 0);
      wr(3'd4, 16'h0002);
      chk("R5 restart issues", 32'(card_req), 1);
      ack(5'd0, '0);
      @(negedge clk);
      rd(3'd5, v); chk("R7 class0 done", 32'(v[13]), 1);

      // sweep classes against byte counts
      for (int t = 0; t < 4; t++) begin
         for (int len = 0; len <= 16; len++) begin
            int n;
            int need;
            bit ok, den, dir;
            logic [5:0] ci;
            logic [31:0] ea;
            n   = t * 17 + len;
            ci  = 6'(n * 5 + 1);
            ea  = 32'(n) * 32'h0101_0F0F + 32'h1357;
            den = len[0];
            dir = len[1];
            need = (t == 0) ? 0 : (t == 2) ? 16 : 4;
            ok  = (len >= need);
            for (int i = 0; i < 16; i++) bv[i*8 +: 8] = pat(n, i);
            wr(3'd0, 16'(ci));
            wr(3'd1, ea[31:16]);
            wr(3'd2, ea[15:0]);
            wr(3'd3, 16'(t) | (16'(den) << 2) | (16'(dir) << 3));
            chk("R4 sweep req", 32'(card_req), 1);
            chk("R4 sweep cmd", 32'(card_cmd), 32'(ci));
            chk("R4 sweep arg", card_arg, ea);
            ack(5'(len), bv);
            chk("R6 sweep end", 32'(evt_end_cmd), 1);
            chk("R10 start", 32'(data_start), 32'(ok && den));
            if (ok && den) chk("R10 direction", 32'(data_write), 32'(dir));
            @(negedge clk);
            chk("R10 start single", 32'(data_start), 0);
            rd(3'd5, v);
            chk("R7 sweep timeout", 32'(v[1]), 32'(!ok));
            chk("R8 sweep done", 32'(v[13]), 32'(ok));
            if (ok) begin
               for (int j = 0; j < 10; j++) begin
                  logic [15:0] e;
                  e = '0;
                  if (2*j < len)   e[7:0]  = pat(n, 2*j);
                  if (2*j+1 < len) e[15:8] = pat(n, 2*j+1);
                  rd(3'd6, v);
                  chk((j < 9) ? "R8 fifo entry" : "R9 past end", 32'(v), 32'(e));
               end
            end
         end
      end

      finish_run();
   end

endmodule